// File: doc/BRIEF.md
# Legacy System Control Port Bank

This block is a byte-wide register bank that sits on a simple port bus of the kind a legacy peripheral bridge exposes. It recognises one special control port, a window of 0x52 ports starting at 0x800, and a pair of scratch ports at 0x398 and 0x399. Writes change control state or fire side effects. Reads return either live state or fixed identification bytes.

The state drives a set of plain control pins: a soft-reset request, a little-endian mode flag, a disk activity lamp, a 4-bit system control field, an I/O map type bit, and two one-clock lock toggle pulses for a pair of non-volatile memory banks. Any port the bank does not recognise reads as 0xFF, and a write to it changes nothing.

Bus transfers are single strobes with no back-pressure. The bank accepts a read or a write on every cycle. Read data comes back one cycle later, marked by a valid pulse. There is no ready signal, because the bank never stalls.

Top module: `sysport_bank`

## Requirements
- R1: On the synchronous reset input, every control output, every stored register, rd_valid and rd_data go to zero, so the soft-reset request is released.
- R2: A write to port 0x092 sets reset_req to data bit 0 and le_mode to data bit 1. Both hold until the next write to 0x092. A read of 0x092 returns 0x00.
- R3: A write to port 0x808 sets lamp_on to data bit 0. The lamp is otherwise held.
- R4: Each write to port 0x810 drives lock_pulse_a high for exactly the following clock cycle, whatever the data. Port 0x812 does the same for lock_pulse_b. Back-to-back writes give back-to-back pulses.
- R5: A write to port 0x81C stores data bits 3:0 in sys_ctl. A read of 0x81C returns that value, with bits 7:4 zero.
- R6: A write to port 0x850 stores data bit 0 in map_sel. A read of 0x850 returns that bit in bit 0, with the other bits zero.
- R7: The identification ports read as fixed bytes: 0x800→0xEF, 0x802→0xAD, 0x803→0xE0, 0x80C→0x3C, 0x810→0x39, 0x818→0x00, 0x823→0x03. Writes to 0x800, 0x802 and 0x803 have no effect.
- R8: A read of any port not listed in R2 to R7 or R9 returns 0xFF. This includes 0x808, 0x812 and 0x814 inside the window, and addresses outside every range. A write to such a port changes no output and no readable state.
- R9: Ports 0x398 and 0x399 are two independent 8-bit registers. Each reads back the last byte written to it.
- R10: A read strobe in cycle N gives rd_valid high in cycle N+1 with the data. When no read was strobed, rd_valid is low and rd_data is zero. A read and a write in the same cycle return the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Port address of the transfer |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe, one transfer per cycle |
| rd_valid | output | 1 | Read data valid, one cycle after bus_rd |
| rd_data | output | 8 | Registered read data, zero when not valid |
| reset_req | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| lamp_on | output | 1 | Disk activity lamp |
| sys_ctl | output | 4 | System control field |
| map_sel | output | 1 | I/O map type bit |
| lock_pulse_a | output | 1 | One-cycle lock toggle for memory bank 1 |
| lock_pulse_b | output | 1 | One-cycle lock toggle for memory bank 2 |

## Verification
The hardest cases to reach from the ports are those where two transfers overlap in time. One is a read and a write to the same register in one cycle, which must return the old value. The other is two writes to a lock port on consecutive cycles, which must give a two-cycle-long run of pulses rather than one merged pulse. Directed sequences build both cases on purpose. A long stretch of random strobes then follows, drawn from a mix of decoded and undecoded addresses. A behavioural model checks every output on every clock, so any stray state change from an ignored write shows up at once.

// File: rtl/sysport_pkg.sv
package sysport_pkg;
  typedef enum logic [3:0] {
    P_NONE,
    P_SPECIAL,
    P_ID_CFG,
    P_ID_FEAT,
    P_ID_STAT,
    P_LAMP,
    P_EQUIP,
    P_LOCK1,
    P_LOCK2,
    P_KEY,
    P_SYSCTL,
    P_CACHE,
    P_MAP,
    P_SCRATCH
  } port_e;

  localparam logic [7:0] ID_CFG_VAL   = 8'hEF;
  localparam logic [7:0] ID_FEAT_VAL  = 8'hAD;
  localparam logic [7:0] ID_STAT_VAL  = 8'hE0;
  localparam logic [7:0] EQUIP_VAL    = 8'h3C;
  localparam logic [7:0] EXTFEAT_VAL  = 8'h39;
  localparam logic [7:0] KEY_VAL      = 8'h00;
  localparam logic [7:0] CACHE_VAL    = 8'h03;
  localparam logic [7:0] SPECIAL_RVAL = 8'h00;
  localparam logic [7:0] UNMAPPED_VAL = 8'hFF;
endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
  import sysport_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SPECIAL_ADDR = 'h092,
  parameter int unsigned WIN_BASE     = 'h800,
  parameter int unsigned WIN_SIZE     = 'h52,
  parameter int unsigned SCR_BASE     = 'h398,
  parameter int unsigned SCR_N        = 2,
  localparam int unsigned SCR_IW      = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             sel,
  output logic [SCR_IW-1:0] scr_idx
);
  logic [ADDR_W-1:0] win_off;
  logic [ADDR_W-1:0] scr_off;

  assign win_off = addr - ADDR_W'(WIN_BASE);
  assign scr_off = addr - ADDR_W'(SCR_BASE);
  assign scr_idx = scr_off[SCR_IW-1:0];

  always_comb begin
    sel = P_NONE;
    if (addr == ADDR_W'(SPECIAL_ADDR)) begin
      sel = P_SPECIAL;
    end else if (scr_off < ADDR_W'(SCR_N)) begin
      sel = P_SCRATCH;
    end else if (win_off < ADDR_W'(WIN_SIZE)) begin
      case (win_off)
        ADDR_W'('h00): sel = P_ID_CFG;
        ADDR_W'('h02): sel = P_ID_FEAT;
        ADDR_W'('h03): sel = P_ID_STAT;
        ADDR_W'('h08): sel = P_LAMP;
        ADDR_W'('h0C): sel = P_EQUIP;
        ADDR_W'('h10): sel = P_LOCK1;
        ADDR_W'('h12): sel = P_LOCK2;
        ADDR_W'('h18): sel = P_KEY;
        ADDR_W'('h1C): sel = P_SYSCTL;
        ADDR_W'('h23): sel = P_CACHE;
        ADDR_W'('h50): sel = P_MAP;
        default:       sel = P_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sysport_regs.sv
module sysport_regs
  import sysport_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SC_W   = 4,
  parameter int unsigned SCR_N  = 2,
  localparam int unsigned SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  port_e                   sel,
  input  logic [SCR_IW-1:0]       scr_idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    reset_req,
  output logic                    le_mode,
  output logic                    lamp_on,
  output logic [SC_W-1:0]         sys_ctl,
  output logic                    map_sel,
  output logic                    lock_a,
  output logic                    lock_b,
  output logic [SCR_N*DATA_W-1:0] scr_flat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reset_req <= 1'b0;
      le_mode   <= 1'b0;
      lamp_on   <= 1'b0;
      sys_ctl   <= '0;
      map_sel   <= 1'b0;
      lock_a    <= 1'b0;
      lock_b    <= 1'b0;
    end else begin
      lock_a <= wr_en && (sel == P_LOCK1);
      lock_b <= wr_en && (sel == P_LOCK2);
      if (wr_en) begin
        case (sel)
          P_SPECIAL: begin
            reset_req <= wdata[0];
            le_mode   <= wdata[1];
          end
          P_LAMP:   lamp_on <= wdata[0];
          P_SYSCTL: sys_ctl <= wdata[SC_W-1:0];
          P_MAP:    map_sel <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    logic [DATA_W-1:0] val;
    always_ff @(posedge clk) begin
      if (rst) val <= '0;
      else if (wr_en && sel == P_SCRATCH && scr_idx == SCR_IW'(g)) val <= wdata;
    end
    assign scr_flat[g*DATA_W +: DATA_W] = val;
  end

  p_lock_a_cause_r4: assert property (@(posedge clk) disable iff (rst)
    lock_a |-> $past(wr_en && sel == P_LOCK1));
  p_lock_b_cause_r4: assert property (@(posedge clk) disable iff (rst)
    lock_b |-> $past(wr_en && sel == P_LOCK2));
  p_reset_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == P_SPECIAL) |=> $stable(reset_req) && $stable(le_mode));
  p_lamp_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == P_LAMP) |=> $stable(lamp_on));
  p_map_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == P_MAP) |=> $stable(map_sel));
endmodule

// File: rtl/sysport_rdmux.sv
module sysport_rdmux
  import sysport_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SC_W   = 4,
  parameter int unsigned SCR_N  = 2,
  localparam int unsigned SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  port_e                   sel,
  input  logic [SCR_IW-1:0]       scr_idx,
  input  logic [SC_W-1:0]         sys_ctl,
  input  logic                    map_sel,
  input  logic [SCR_N*DATA_W-1:0] scr_flat,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (sel)
      P_SPECIAL: rd_next = DATA_W'(SPECIAL_RVAL);
      P_ID_CFG:  rd_next = DATA_W'(ID_CFG_VAL);
      P_ID_FEAT: rd_next = DATA_W'(ID_FEAT_VAL);
      P_ID_STAT: rd_next = DATA_W'(ID_STAT_VAL);
      P_EQUIP:   rd_next = DATA_W'(EQUIP_VAL);
      P_LOCK1:   rd_next = DATA_W'(EXTFEAT_VAL);
      P_KEY:     rd_next = DATA_W'(KEY_VAL);
      P_CACHE:   rd_next = DATA_W'(CACHE_VAL);
      P_SYSCTL:  rd_next = DATA_W'(sys_ctl);
      P_MAP:     rd_next = DATA_W'(map_sel);
      P_SCRATCH: rd_next = scr_flat[scr_idx*DATA_W +: DATA_W];
      default:   rd_next = DATA_W'(UNMAPPED_VAL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_next : '0;
    end
  end

  p_unmapped_ff_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == P_NONE) |=> rd_data == DATA_W'(UNMAPPED_VAL));
  p_sysctl_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == P_SYSCTL) |=> rd_data[DATA_W-1:SC_W] == '0);
  p_special_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == P_SPECIAL) |=> rd_data == '0);
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0);
endmodule

// File: rtl/sysport_bank.sv
module sysport_bank
  import sysport_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SC_W         = 4,
  parameter int unsigned SPECIAL_ADDR = 'h092,
  parameter int unsigned WIN_BASE     = 'h800,
  parameter int unsigned WIN_SIZE     = 'h52,
  parameter int unsigned SCR_BASE     = 'h398,
  parameter int unsigned SCR_N        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req,
  output logic              le_mode,
  output logic              lamp_on,
  output logic [SC_W-1:0]   sys_ctl,
  output logic              map_sel,
  output logic              lock_pulse_a,
  output logic              lock_pulse_b
);
  localparam int unsigned SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;

  port_e                   sel;
  logic [SCR_IW-1:0]       scr_idx;
  logic [SCR_N*DATA_W-1:0] scr_flat;

  sysport_decode #(
    .ADDR_W(ADDR_W), .SPECIAL_ADDR(SPECIAL_ADDR), .WIN_BASE(WIN_BASE),
    .WIN_SIZE(WIN_SIZE), .SCR_BASE(SCR_BASE), .SCR_N(SCR_N)
  ) dec_i (
    .addr(bus_addr), .sel(sel), .scr_idx(scr_idx)
  );

  sysport_regs #(.DATA_W(DATA_W), .SC_W(SC_W), .SCR_N(SCR_N)) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .sel(sel), .scr_idx(scr_idx),
    .wdata(bus_wdata), .reset_req(reset_req), .le_mode(le_mode),
    .lamp_on(lamp_on), .sys_ctl(sys_ctl), .map_sel(map_sel),
    .lock_a(lock_pulse_a), .lock_b(lock_pulse_b), .scr_flat(scr_flat)
  );

  sysport_rdmux #(.DATA_W(DATA_W), .SC_W(SC_W), .SCR_N(SCR_N)) rdmux_i (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .sel(sel), .scr_idx(scr_idx),
    .sys_ctl(sys_ctl), .map_sel(map_sel), .scr_flat(scr_flat),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  p_rd_latency_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);
  p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !rd_valid);
  p_locks_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(lock_pulse_a && lock_pulse_b));
endmodule

// File: tb/sysport_bank_tb_top.sv
`timescale 1ns/1ps
module sysport_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        reset_req, le_mode, lamp_on, map_sel, lock_pulse_a, lock_pulse_b;
  logic [3:0]  sys_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysport_bank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_valid(rd_valid), .rd_data(rd_data),
    .reset_req(reset_req), .le_mode(le_mode), .lamp_on(lamp_on),
    .sys_ctl(sys_ctl), .map_sel(map_sel), .lock_pulse_a(lock_pulse_a),
    .lock_pulse_b(lock_pulse_b)
  );

  // behavioural reference state
  bit       m_rreq, m_le, m_lamp, m_map, m_la, m_lb, m_rv;
  bit [3:0] m_sc;
  bit [7:0] m_scr[2];
  bit [7:0] m_rd;
  string    m_rd_tag;

  function automatic bit [7:0] model_read(input bit [15:0] a, output string tag);
    tag = "R7";
    case (a)
      16'h0092: begin tag = "R2"; return 8'h00; end
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: begin tag = "R5"; return {4'h0, m_sc}; end
      16'h0850: begin tag = "R6"; return {7'h0, m_map}; end
      16'h0398: begin tag = "R9"; return m_scr[0]; end
      16'h0399: begin tag = "R9"; return m_scr[1]; end
      default:  begin tag = "R8"; return 8'hFF; end
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string base_tag);
    chk(base_tag == "" ? "R2" : base_tag, reset_req, m_rreq, "reset_req");
    chk(base_tag == "" ? "R2" : base_tag, le_mode, m_le, "le_mode");
    chk(base_tag == "" ? "R3" : base_tag, lamp_on, m_lamp, "lamp_on");
    chk(base_tag == "" ? "R4" : base_tag, lock_pulse_a, m_la, "lock_pulse_a");
    chk(base_tag == "" ? "R4" : base_tag, lock_pulse_b, m_lb, "lock_pulse_b");
    chk(base_tag == "" ? "R5" : base_tag, sys_ctl, m_sc, "sys_ctl");
    chk(base_tag == "" ? "R6" : base_tag, map_sel, m_map, "map_sel");
    chk(base_tag == "" ? "R10" : base_tag, rd_valid, m_rv, "rd_valid");
    chk(base_tag == "" ? m_rd_tag : base_tag, rd_data, m_rd, "rd_data");
  endtask

  task automatic step(input bit wr, input bit rd, input bit [15:0] a, input bit [7:0] d);
    string tag;
    @(negedge clk);
    rst = 1'b0; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    // read sees the state from before a same-cycle write (R10)
    m_rv = rd;
    m_rd = rd ? model_read(a, tag) : 8'h00;
    m_rd_tag = rd ? tag : "R10";
    m_la = wr && a == 16'h0810;
    m_lb = wr && a == 16'h0812;
    if (wr) begin
      case (a)
        16'h0092: begin m_rreq = d[0]; m_le = d[1]; end
        16'h0808: m_lamp = d[0];
        16'h081C: m_sc = d[3:0];
        16'h0850: m_map = d[0];
        16'h0398: m_scr[0] = d;
        16'h0399: m_scr[1] = d;
        default: ;
      endcase
    end
    #1 compare_all("");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 16'h0; bus_wdata = 8'h0;
    repeat (2) @(posedge clk);
    m_rreq = 0; m_le = 0; m_lamp = 0; m_map = 0; m_la = 0; m_lb = 0; m_rv = 0;
    m_sc = 0; m_scr[0] = 0; m_scr[1] = 0; m_rd = 0; m_rd_tag = "R1";
    #1 compare_all("R1");
    // scratch registers cleared by reset
    step(0, 1, 16'h0398, 0);
    step(0, 1, 16'h0399, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam bit [15:0] POOL [16] = '{16'h0092, 16'h0800, 16'h0802, 16'h0803,
    16'h0808, 16'h080C, 16'h0810, 16'h0812, 16'h0814, 16'h0818, 16'h081C,
    16'h0823, 16'h0850, 16'h0398, 16'h0399, 16'h0851};

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    do_reset();                                  // R1

    // R2: special port
    step(1, 0, 16'h0092, 8'h03);
    step(0, 1, 16'h0092, 8'h00);
    step(1, 0, 16'h0092, 8'h02);
    step(0, 0, 16'h0000, 8'h00);
    step(1, 0, 16'h0092, 8'hFC);
    // R3: lamp
    step(1, 0, 16'h0808, 8'hFF);
    step(0, 0, 16'h0000, 8'h00);
    step(1, 0, 16'h0808, 8'hFE);
    // R4: lock pulses, any data, back to back
    step(1, 0, 16'h0810, 8'h00);
    step(0, 0, 16'h0000, 8'h00);
    step(1, 0, 16'h0812, 8'hAA);
    step(0, 0, 16'h0000, 8'h00);
    step(1, 0, 16'h0810, 8'h55);
    step(1, 0, 16'h0810, 8'h55);
    step(1, 0, 16'h0812, 8'h01);
    step(0, 0, 16'h0000, 8'h00);
    // R5: system control, upper nibble dropped
    step(1, 0, 16'h081C, 8'hA7);
    step(0, 1, 16'h081C, 8'h00);
    // R6: map type
    step(1, 0, 16'h0850, 8'hFE);
    step(0, 1, 16'h0850, 8'h00);
    step(1, 0, 16'h0850, 8'h03);
    step(0, 1, 16'h0850, 8'h00);
    // R7: identification bytes and ignored writes
    foreach (POOL[i]) step(0, 1, POOL[i], 8'h00);
    step(1, 0, 16'h0800, 8'h12);
    step(1, 0, 16'h0802, 8'h34);
    step(1, 0, 16'h0803, 8'h56);
    step(0, 1, 16'h0800, 8'h00);
    // R8: undecoded ports
    step(0, 1, 16'h0801, 8'h00);
    step(0, 1, 16'h0814, 8'h00);
    step(0, 1, 16'h0852, 8'h00);
    step(0, 1, 16'h1234, 8'h00);
    step(0, 1, 16'h039A, 8'h00);
    step(1, 0, 16'h0801, 8'hFF);
    step(1, 0, 16'h0814, 8'hFF);
    step(1, 0, 16'h0851, 8'hFF);
    step(1, 0, 16'h1234, 8'hFF);
    step(1, 0, 16'h0093, 8'hFF);
    step(0, 1, 16'h081C, 8'h00);
    // R9: scratch pair
    step(1, 0, 16'h0398, 8'h5A);
    step(1, 0, 16'h0399, 8'hC3);
    step(0, 1, 16'h0398, 8'h00);
    step(0, 1, 16'h0399, 8'h00);
    step(1, 0, 16'h0399, 8'h11);
    step(0, 1, 16'h0398, 8'h00);
    // R10: read and write together return old value
    step(1, 1, 16'h081C, 8'h05);
    step(0, 1, 16'h081C, 8'h00);
    step(1, 1, 16'h0398, 8'h99);
    step(0, 1, 16'h0398, 8'h00);
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit [15:0] a = POOL[$urandom_range(15)];
      step(1'($urandom), 1'($urandom), a, 8'($urandom));
    end
    // R1: reset mid-run after state is set
    step(1, 0, 16'h0092, 8'h03);
    step(1, 0, 16'h081C, 8'h0F);
    do_reset();
    step(0, 1, 16'h081C, 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule